// File: doc/BRIEF.md
# Free-Running Capture Timer

This block is a peripheral timer with one free-running up-counter and four capture registers. The counter starts at zero when reset is released. It advances once every four bus clocks and software cannot stop it. It wraps from all ones back to zero without raising any event.

Each of four external event inputs is synchronized to the bus clock. A rising edge on an input copies the current count into that input's own capture register. The same edge sets a sticky request flag, and the interrupt output is high while any flag is set. Software clears flags through a control register. All registers are 32 bits wide and are reached over a 16-bit peripheral bus as two halfwords. Reading the upper half of the counter latches the lower half, so a two-step read gives a consistent value.

The bus has no back-pressure. A request is taken in the cycle it is presented: there is no ready signal and no wait state, and read data is valid in that same cycle while `bus_req` is high and `bus_wr` is low. The event inputs and the interrupt output are plain level signals.

Top module: `evt_capture_timer`

## Requirements
- R1: While `rst_n` is low the counter is zero. When `k` rising clock edges have passed since reset release, the counter holds floor(k/4) modulo 2^CNT_W. The first step therefore happens on the 4th edge, and the counter never holds a value for more than four edges.
- R2: Bus writes cannot stop or change the counter. A write to any counter, capture or unused offset leaves the count on its normal schedule.
- R3: An input `meas_i[n]` that is low at one clock edge and high at the next (edge e) causes a capture at edge e+2. At that edge, capture register n receives the count held just before the edge. If the counter steps at that same edge, the value before the step is captured.
- R4: Byte offsets, with each upper halfword at the lower address: counter upper half at 0x00 and lower half at 0x02; control register at 0x0A; capture register n upper half at 0x1C-4n and lower half at 0x1E-4n.
- R5: Reading 0x0A returns the request flags in bits [3:0], with bit n belonging to input n and bits [15:4] zero. A flag is set at the capture edge of its input. Writing 1 to bit n of 0x0A clears flag n, and writing 0 leaves it as it is. If a set and a clear meet in the same edge, the flag stays set.
- R6: `irq_o` is high exactly when at least one request flag is set.
- R7: When the counter wraps from all ones to zero, no flag is set and `irq_o` does not rise.
- R8: A read of 0x00 latches the counter's lower halfword at that clock edge. A read of 0x02 returns that latched value, and the value is zero after reset until the first read of 0x00.
- R9: Reads of offsets not named in R4 return zero, including odd offsets, and writes to them have no effect. `bus_rdata` is zero when no read is requested.
- R10: A capture needs a rising edge. An input held high, or a falling edge, causes no further capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_i | input | 4 | External event inputs, asynchronous to `clk` |
| bus_req | input | 1 | Bus request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the halfword |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, same cycle as the request |
| irq_o | output | 1 | Interrupt request, OR of the four flags |

## Verification
Two functions can fall on the same clock edge: a capture and a counter step. The bench waits until the reference model's edge count puts the capture edge on a step boundary, then raises an input. It then checks that the captured value is the count before the step, not after it. A flag set and a software clear can also meet on one edge. The bench provokes this by placing a clear write on the capture edge, and judges it by reading the control register afterwards, where the flag must still be set.

// File: rtl/ect_pkg.sv
package ect_pkg;
  localparam int BUS_DW = 16;
  localparam int BUS_AW = 5;
  localparam int N_MEAS = 4;
  localparam int REG_W  = 32;

  localparam logic [BUS_AW-1:0] OFS_CNT_HI = 5'h00;
  localparam logic [BUS_AW-1:0] OFS_CNT_LO = 5'h02;
  localparam logic [BUS_AW-1:0] OFS_CTRL   = 5'h0A;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CNT_HI,
    SEL_CNT_LO,
    SEL_CTRL,
    SEL_CAP_HI,
    SEL_CAP_LO
  } sel_e;

  typedef struct packed {
    sel_e       sel;
    logic [1:0] ch;
  } dec_t;

  // Capture block occupies 0x10..0x1F; group 0 (0x10) is channel 3.
  function automatic dec_t decode(logic [BUS_AW-1:0] a);
    dec_t d;
    d.sel = SEL_NONE;
    d.ch  = 2'd0;
    if (a == OFS_CNT_HI)      d.sel = SEL_CNT_HI;
    else if (a == OFS_CNT_LO) d.sel = SEL_CNT_LO;
    else if (a == OFS_CTRL)   d.sel = SEL_CTRL;
    else if (a[4] && !a[0]) begin
      d.sel = a[1] ? SEL_CAP_LO : SEL_CAP_HI;
      d.ch  = 2'd3 - a[3:2];
    end
    return d;
  endfunction
endpackage

// File: rtl/ect_timebase.sv
module ect_timebase #(
  parameter int CNT_W    = 32,
  parameter int DIV_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             tick,
  output logic [CNT_W-1:0] count
);
  logic [DIV_LOG2-1:0] pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre <= '0;
    else        pre <= pre + 1'b1;
  end

  assign tick = &pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (tick) count <= count + 1'b1;
  end
endmodule

// File: rtl/ect_edge_sync.sv
module ect_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/ect_capture_bank.sv
module ect_capture_bank #(
  parameter int CNT_W = 32,
  parameter int N_CH  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_CH-1:0]            rise,
  input  logic [CNT_W-1:0]           count,
  output logic [N_CH-1:0][CNT_W-1:0] cap
);
  for (genvar i = 0; i < N_CH; i++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cap[i] <= '0;
      else if (rise[i]) cap[i] <= count;
    end
  end
endmodule

// File: rtl/ect_regs.sv
module ect_regs
  import ect_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int N_CH  = N_MEAS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req,
  input  logic                       wr,
  input  logic [BUS_AW-1:0]          addr,
  input  logic [BUS_DW-1:0]          wdata,
  input  logic [CNT_W-1:0]           count,
  input  logic [N_CH-1:0][CNT_W-1:0] cap,
  input  logic [N_CH-1:0]            rise,
  output logic [BUS_DW-1:0]          rdata,
  output logic [N_CH-1:0]            flags,
  output logic                       irq
);
  localparam int HALF = REG_W / 2;

  dec_t             d;
  logic             rd_en;
  logic             wr_en;
  logic [REG_W-1:0] cnt_x;
  logic [REG_W-1:0] cap_x;
  logic [HALF-1:0]  shadow;
  logic [N_CH-1:0]  clr;
  logic             unused_wbits;

  assign d      = decode(addr);
  assign rd_en  = req & ~wr;
  assign wr_en  = req & wr;
  assign cnt_x  = REG_W'(count);
  assign cap_x  = REG_W'(cap[d.ch]);
  assign clr    = (wr_en && d.sel == SEL_CTRL) ? wdata[N_CH-1:0] : '0;
  assign unused_wbits = ^wdata[BUS_DW-1:N_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        shadow <= '0;
    else if (rd_en && d.sel == SEL_CNT_HI) shadow <= cnt_x[HALF-1:0];
  end

  // a new event outranks a clear landing on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | rise;
  end

  assign irq = |flags;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (d.sel)
        SEL_CNT_HI: rdata = cnt_x[REG_W-1:HALF];
        SEL_CNT_LO: rdata = shadow;
        SEL_CTRL:   rdata = BUS_DW'(flags);
        SEL_CAP_HI: rdata = cap_x[REG_W-1:HALF];
        SEL_CAP_LO: rdata = cap_x[HALF-1:0];
        default:    rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/evt_capture_timer.sv
module evt_capture_timer
  import ect_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_LOG2    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_MEAS-1:0] meas_i,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              irq_o
);
  logic                         tick;
  logic [CNT_W-1:0]             count;
  logic [N_MEAS-1:0]            rise;
  logic [N_MEAS-1:0][CNT_W-1:0] cap;
  logic [N_MEAS-1:0]            flags;

  ect_timebase #(.CNT_W(CNT_W), .DIV_LOG2(DIV_LOG2)) u_tb (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count(count)
  );

  for (genvar i = 0; i < N_MEAS; i++) begin : g_in
    ect_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(meas_i[i]), .rise(rise[i])
    );
  end

  ect_capture_bank #(.CNT_W(CNT_W), .N_CH(N_MEAS)) u_caps (
    .clk(clk), .rst_n(rst_n), .rise(rise), .count(count), .cap(cap)
  );

  ect_regs #(.CNT_W(CNT_W), .N_CH(N_MEAS)) u_regs (
    .clk(clk), .rst_n(rst_n), .req(bus_req), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .count(count), .cap(cap), .rise(rise),
    .rdata(bus_rdata), .flags(flags), .irq(irq_o)
  );
endmodule

// File: rtl/ect_checker.sv
module ect_checker #(
  parameter int CNT_W = 32,
  parameter int N_CH  = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       tick,
  input logic [CNT_W-1:0]           count,
  input logic [N_CH-1:0]            rise,
  input logic [N_CH-1:0][CNT_W-1:0] cap,
  input logic [N_CH-1:0]            flags,
  input logic                       irq_o
);
  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);                                             // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> count == CNT_W'($past(count) + 1'b1));              // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));                                   // R1
  AST_WRAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (&count) && flags == '0 && rise == '0) |=> !irq_o); // R7

  for (genvar i = 0; i < N_CH; i++) begin : g_chk
    AST_CAP_PRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      rise[i] |=> cap[i] == $past(count));                       // R3
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      rise[i] |=> flags[i] && irq_o);                            // R5
    AST_CAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rise[i] |=> $stable(cap[i]));                             // R10
  end
endmodule

bind evt_capture_timer ect_checker #(.CNT_W(CNT_W), .N_CH(ect_pkg::N_MEAS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .count(count), .rise(rise),
  .cap(cap), .flags(flags), .irq_o(irq_o)
);

// File: tb/evt_capture_timer_bench.sv
module evt_capture_timer_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  meas = 0;
  logic        bus_req = 0, bus_wr = 0;
  logic [4:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] rdata_m, rdata_n;
  logic        irq_m, irq_n;

  always #4 clk = ~clk;

  evt_capture_timer u_evt_capture_timer (
    .clk(clk), .rst_n(rst_n), .meas_i(meas), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_m), .irq_o(irq_m));

  evt_capture_timer #(.CNT_W(4)) u_evt_capture_timer_narrow (
    .clk(clk), .rst_n(rst_n), .meas_i(meas), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_n), .irq_o(irq_n));

  int nchk = 0, nerr = 0;
  bit done = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  longint unsigned edges = 0;
  longint unsigned mcap[2][4];
  longint unsigned mshadow[2];
  bit [3:0]        mflag = 0;
  bit [3:0]        hist[$] = '{4'h0, 4'h0, 4'h0, 4'h0};

  function automatic longint unsigned mcnt(int m);
    longint unsigned c = edges / 4;
    return (m == 0) ? (c & 64'hFFFF_FFFF) : (c % 16);
  endfunction

  always @(posedge clk) begin
    bit [3:0] rs;
    if (!rst_n) begin
      edges = 0; mflag = 0; hist = '{4'h0, 4'h0, 4'h0, 4'h0};
      for (int m = 0; m < 2; m++) begin
        mshadow[m] = 0;
        for (int n = 0; n < 4; n++) mcap[m][n] = 0;
      end
    end else begin
      hist.push_front(meas);
      rs = hist[2] & ~hist[3];
      void'(hist.pop_back());
      for (int m = 0; m < 2; m++) begin
        if (bus_req && !bus_wr && bus_addr == 5'h00) mshadow[m] = mcnt(m) & 16'hFFFF;
        for (int n = 0; n < 4; n++) if (rs[n]) mcap[m][n] = mcnt(m);
      end
      if (bus_req && bus_wr && bus_addr == 5'h0A) mflag = mflag & ~bus_wdata[3:0];
      mflag = mflag | rs;
      edges++;
    end
  end

  function automatic longint exp_rd(int m);
    longint unsigned v;
    int n;
    if (!bus_req || bus_wr) return 0;
    if (bus_addr == 5'h00) return (mcnt(m) >> 16) & 16'hFFFF;
    if (bus_addr == 5'h02) return mshadow[m];
    if (bus_addr == 5'h0A) return mflag;
    if (bus_addr >= 5'h10 && !bus_addr[0]) begin
      n = (32'h1C - (bus_addr & 5'h1D)) / 4;
      v = mcap[m][n];
      return bus_addr[1] ? (v & 16'hFFFF) : ((v >> 16) & 16'hFFFF);
    end
    return 0;
  endfunction

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      #2;
      chk("R4 R8 R9 cycle main rdata", rdata_m, exp_rd(0));
      chk("R4 R7 cycle narrow rdata", rdata_n, exp_rd(1));
      chk("R6 cycle irq", irq_m, |mflag);
      chk("R6 cycle narrow irq", irq_n, |mflag);
    end
  end

  // ---------------- stimulus helpers ----------------
  logic [15:0]     rd_m, rd_n;
  longint unsigned rd_e;

  task automatic rd(input logic [4:0] a);
    @(negedge clk);
    bus_req = 1; bus_wr = 0; bus_addr = a; bus_wdata = 0; rd_e = edges;
    #2; rd_m = rdata_m; rd_n = rdata_n;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_req = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      bus_req = 0; bus_wr = 0; bus_wdata = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    longint unsigned e0, lo0, c1;
    // reset state (R1)
    repeat (3) @(negedge clk);
    bus_req = 1; bus_addr = 5'h00;
    #2;
    chk("R1 counter upper in reset", rdata_m, 0);
    chk("R6 irq in reset", irq_m, 0);
    @(negedge clk); bus_addr = 5'h02; #2;
    chk("R8 shadow zero after reset", rdata_m, 0);
    @(negedge clk); bus_req = 0; rst_n = 1;

    // R1 counter schedule, R7 narrow wrap
    idle(70);
    rd(5'h00); e0 = rd_e;
    chk("R1 upper half small count", rd_m, 0);
    rd(5'h02);
    chk("R1 count floor(k/4)", rd_m, (e0 / 4) & 16'hFFFF);
    chk("R7 narrow wrapped count", rd_n, (e0 / 4) % 16);
    chk("R7 no irq after wrap", irq_n, 0);

    // R8 shadow keeps old value
    rd(5'h00); e0 = rd_e; lo0 = (e0 / 4) & 16'hFFFF;
    idle(12);
    rd(5'h02);
    chk("R8 lower read returns latched value", rd_m, lo0);

    // R2 writes cannot touch the counter, R9 unused offsets
    wr(5'h00, 16'hFFFF); wr(5'h02, 16'hFFFF); wr(5'h10, 16'hFFFF);
    wr(5'h04, 16'hFFFF); wr(5'h0C, 16'h00FF);
    rd(5'h00); e0 = rd_e;
    rd(5'h02);
    chk("R2 counter unaffected by writes", rd_m, (e0 / 4) & 16'hFFFF);
    rd(5'h1E);
    chk("R2 capture unaffected by writes", rd_m, 0);
    rd(5'h04); chk("R9 unused 0x04 reads zero", rd_m, 0);
    rd(5'h0C); chk("R9 unused 0x0C reads zero", rd_m, 0);
    rd(5'h11); chk("R9 odd offset reads zero", rd_m, 0);
    idle(1); #2;
    chk("R9 no read request gives zero", rdata_m, 0);

    // R3 simple capture on channel 0
    @(negedge clk); meas[0] = 1; e0 = edges;
    idle(3); meas[0] = 0;
    idle(3);
    rd(5'h1E);
    chk("R3 channel 0 capture", rd_m, ((e0 + 2) / 4) & 16'hFFFF);
    rd(5'h1C);
    chk("R4 channel 0 upper at 0x1C", rd_m, 0);
    chk("R6 irq after capture", irq_m, 1);
    rd(5'h0A);
    chk("R5 flag 0 set", rd_m, 16'h0001);

    // R3 capture coinciding with a counter step, channel 1
    @(negedge clk);
    while (((edges + 3) % 4) != 0) @(negedge clk);
    bus_req = 0; meas[1] = 1; e0 = edges;
    idle(5);
    rd(5'h1A); c1 = rd_m;
    chk("R3 pre-step value captured", rd_m, ((e0 + 2) / 4) & 16'hFFFF);
    rd(5'h0A);
    chk("R5 flags 0 and 1", rd_m, 16'h0003);

    // R5 clear semantics
    wr(5'h0A, 16'h0001);
    rd(5'h0A); chk("R5 write 1 clears bit 0", rd_m, 16'h0002);
    wr(5'h0A, 16'h0000);
    rd(5'h0A); chk("R5 write 0 leaves flags", rd_m, 16'h0002);

    // R5 set beats clear on the same edge, channel 2
    @(negedge clk); bus_req = 0; meas[2] = 1; e0 = edges;
    @(negedge clk);
    wr(5'h0A, 16'h0004);
    idle(2);
    rd(5'h0A); chk("R5 set wins over clear", rd_m, 16'h0006);

    // R10 level high and falling edge do not capture
    idle(20);
    rd(5'h1A); chk("R10 held high no recapture", rd_m, c1);
    meas[1] = 0; meas[2] = 0;
    idle(12);
    rd(5'h1A); chk("R10 falling edge no capture", rd_m, c1);

    // R3 all channels together
    @(negedge clk); bus_req = 0; meas = 4'hF; e0 = edges;
    idle(6);
    rd(5'h12); chk("R3 channel 3 lower at 0x12", rd_m, ((e0 + 2) / 4) & 16'hFFFF);
    rd(5'h16); chk("R4 channel 2 lower at 0x16", rd_m, ((e0 + 2) / 4) & 16'hFFFF);
    rd(5'h0A); chk("R5 all flags set", rd_m, 16'h000F);
    chk("R7 narrow capture masked", rd_n, 16'h000F);

    // R6 clear all drops irq
    wr(5'h0A, 16'hFFFF);
    idle(1); #2;
    chk("R6 irq low after clearing all flags", irq_m, 0);
    meas = 0;
    idle(6);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule